// File: doc/BRIEF.md
# Round-Trip Delay Autocalibrating Pipeline

This block is a receive-path delay line whose length changes at run time so that an externally measured round-trip delay settles on a value chosen by software. Incoming words pass through a chain of register stages. A tap pointer selects the stage that drives the output, so the pointer value is the latency of the path in clock cycles.

Software loads a target delay. Each time a fresh round-trip measurement arrives with its valid strobe, the block compares it with the target. It then moves the tap by at most one stage: down when the measured delay is too long, up when it is too short. A two-bit calibration status tells software whether the loop is locked, still adjusting or waiting, or pinned against either end of the chain. When the status is pinned, the target is out of reach and software should pick another.

Top module: `rtd_autocal_pipe`

## Requirements
- R1: After reset the tap reads the middle stage, (STAGES+1)/2 (3 for five stages), and the status reads 2'b00.
- R2: The output word equals the input word sampled `tap` clock edges earlier, so the latency follows the tap. A tap change therefore repeats or skips exactly one word. The tap never leaves the range 1 to STAGES.
- R3: A valid measurement greater than the target, with the tap above 1, lowers the tap by one and sets the status to 2'b00.
- R4: A valid measurement smaller than the target, with the tap below STAGES, raises the tap by one and sets the status to 2'b00.
- R5: A valid measurement equal to the target leaves the tap unchanged and sets the status to 2'b11 (locked).
- R6: A valid measurement greater than the target while the tap is 1 leaves the tap at 1 and sets the status to 2'b01.
- R7: A valid measurement smaller than the target while the tap is STAGES leaves the tap at STAGES and sets the status to 2'b10.
- R8: A target write sets the status to 2'b00 and does not move the tap. A measurement strobed in the same cycle as a target write is dropped.
- R9: Without a valid strobe, changes on the measurement input move neither the tap nor the status.

Each update to the tap or the status becomes visible on the clock edge that samples its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din_i | input | DATA_W | Receive word entering the delay chain |
| dout_o | output | DATA_W | Word read from the stage selected by the tap |
| tgt_val_i | input | DELAY_W | Target round-trip delay in clock cycles |
| tgt_wr_i | input | 1 | One-cycle strobe that loads tgt_val_i |
| meas_val_i | input | DELAY_W | Measured round-trip delay |
| meas_vld_i | input | 1 | One-cycle strobe marking a fresh measurement |
| tap_o | output | TAP_W | Current tap, 1 to STAGES |
| cal_st_o | output | 2 | 00 waiting/adjusting, 01 too long at floor, 10 too short at ceiling, 11 locked |

## Verification
A strobe on the target or measurement inputs is sampled at one rising edge, and the new tap and status are due right after that same edge. The bench drives stimulus one time unit after a rising edge and compares at the next falling edge, so each result is checked half a cycle after it settles. The output word is due `tap` edges after its input was sampled. The behavioural model keeps a history queue of sampled inputs and indexes it with its own tap, which covers the cycle in which a tap change repeats or skips a word. Reset release passes through two synchronizer flops, and the bench holds all inputs idle for several cycles afterwards so that the model needs no knowledge of that delay.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

  // Calibration status codes seen on cal_st_o
  typedef enum logic [1:0] {
    CAL_WAIT   = 2'b00,  // reset, new target, or tap just moved
    CAL_FLOOR  = 2'b01,  // delay too long, tap already at shortest stage
    CAL_CEIL   = 2'b10,  // delay too short, tap already at longest stage
    CAL_LOCKED = 2'b11   // measured delay equals target
  } cal_st_e;

  // Direction the loop wants to move the tap
  typedef enum logic [1:0] {
    DIR_HOLD  = 2'b00,
    DIR_DOWN  = 2'b01,
    DIR_UP    = 2'b10
  } tap_dir_e;

endpackage

// File: rtl/rtd_rst_sync.sv
module rtd_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ani,
  output logic rst_sno
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ani) begin
    if (!rst_ani) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sno = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/rtd_delay_chain.sv
module rtd_delay_chain #(
  parameter int DATA_W = 16,
  parameter int STAGES = 5,
  parameter int TAP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic [TAP_W-1:0]  tap_i,
  output logic [DATA_W-1:0] dout_o
);

  // stage k (0-based) holds the word sampled k+1 edges ago
  logic [DATA_W-1:0] stg_q [STAGES];
  logic [DATA_W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = din_i;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[g] <= '0;
      end else begin
        stg_q[g] <= stg_d[g];
      end
    end
  end

  // Tap mux: tap value n selects the word delayed by n cycles
  always_comb begin
    dout_o = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (tap_i == TAP_W'(i + 1)) begin
        dout_o = stg_q[i];
      end
    end
  end

  // R2
  tap_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_i >= TAP_W'(1)) && (tap_i <= TAP_W'(STAGES)));

endmodule

// File: rtl/rtd_tap_ctrl.sv
module rtd_tap_ctrl
  import rtd_pkg::*;
#(
  parameter int STAGES  = 5,
  parameter int TAP_W   = 3,
  parameter int DELAY_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DELAY_W-1:0] tgt_val_i,
  input  logic               tgt_wr_i,
  input  logic [DELAY_W-1:0] meas_val_i,
  input  logic               meas_vld_i,
  output logic [TAP_W-1:0]   tap_o,
  output cal_st_e            cal_st_o
);

  localparam logic [TAP_W-1:0] TAP_MIN  = TAP_W'(1);
  localparam logic [TAP_W-1:0] TAP_MAX  = TAP_W'(STAGES);
  localparam logic [TAP_W-1:0] TAP_INIT = TAP_W'((STAGES + 1) / 2);

  logic [DELAY_W-1:0] tgt_q,  tgt_d;
  logic [TAP_W-1:0]   tap_q,  tap_d;
  cal_st_e            st_q,   st_d;
  tap_dir_e           want_dir;
  logic               at_floor, at_ceil;
  logic               upd_en;
  logic               cmp_en;

  // Compare stage: only a measurement not shadowed by a target write counts
  assign cmp_en   = meas_vld_i & ~tgt_wr_i;
  assign at_floor = (tap_q == TAP_MIN);
  assign at_ceil  = (tap_q == TAP_MAX);

  always_comb begin
    if (meas_val_i > tgt_q) begin
      want_dir = DIR_DOWN;
    end else if (meas_val_i < tgt_q) begin
      want_dir = DIR_UP;
    end else begin
      want_dir = DIR_HOLD;
    end
  end

  // Next-state logic
  always_comb begin
    tgt_d = tgt_q;
    tap_d = tap_q;
    st_d  = st_q;
    if (tgt_wr_i) begin
      tgt_d = tgt_val_i;
      st_d  = CAL_WAIT;
    end else if (cmp_en) begin
      unique case (want_dir)
        DIR_DOWN: begin
          if (at_floor) begin
            st_d = CAL_FLOOR;
          end else begin
            tap_d = tap_q - TAP_W'(1);
            st_d  = CAL_WAIT;
          end
        end
        DIR_UP: begin
          if (at_ceil) begin
            st_d = CAL_CEIL;
          end else begin
            tap_d = tap_q + TAP_W'(1);
            st_d  = CAL_WAIT;
          end
        end
        default: begin
          st_d = CAL_LOCKED;
        end
      endcase
    end
  end

  assign upd_en = tgt_wr_i | meas_vld_i;

  // State registers with explicit clock enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
      tap_q <= TAP_INIT;
      st_q  <= CAL_WAIT;
    end else if (upd_en) begin
      tgt_q <= tgt_d;
      tap_q <= tap_d;
      st_q  <= st_d;
    end
  end

  assign tap_o    = tap_q;
  assign cal_st_o = st_q;

  // R3 R4
  tap_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tap_q) |-> ((tap_q == $past(tap_q) + TAP_W'(1)) ||
                          (tap_q == $past(tap_q) - TAP_W'(1))));

  // R8 R9
  tap_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meas_vld_i || tgt_wr_i) |=> $stable(tap_q));

  // R8
  wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_wr_i |=> (cal_st_o == CAL_WAIT));

  // R6
  floor_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_st_o == CAL_FLOOR) |-> (tap_o == TAP_MIN));

  // R7
  ceil_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cal_st_o == CAL_CEIL) |-> (tap_o == TAP_MAX));

  // R3 R4
  move_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tap_q) |-> (cal_st_o == CAL_WAIT));

endmodule

// File: rtl/rtd_autocal_pipe.sv
module rtd_autocal_pipe #(
  parameter int DATA_W  = 16,
  parameter int STAGES  = 5,
  parameter int DELAY_W = 16,
  parameter int TAP_W   = $clog2(STAGES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  din_i,
  output logic [DATA_W-1:0]  dout_o,
  input  logic [DELAY_W-1:0] tgt_val_i,
  input  logic               tgt_wr_i,
  input  logic [DELAY_W-1:0] meas_val_i,
  input  logic               meas_vld_i,
  output logic [TAP_W-1:0]   tap_o,
  output logic [1:0]         cal_st_o
);

  import rtd_pkg::*;

  logic             rst_sync_n;
  logic [TAP_W-1:0] tap_w;
  cal_st_e          st_w;

  rtd_rst_sync #(
    .SYNC_STAGES (2)
  ) u_rst_sync (
    .clk_i   (clk_i),
    .rst_ani (rst_ni),
    .rst_sno (rst_sync_n)
  );

  rtd_tap_ctrl #(
    .STAGES  (STAGES),
    .TAP_W   (TAP_W),
    .DELAY_W (DELAY_W)
  ) u_tap_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .tgt_val_i  (tgt_val_i),
    .tgt_wr_i   (tgt_wr_i),
    .meas_val_i (meas_val_i),
    .meas_vld_i (meas_vld_i),
    .tap_o      (tap_w),
    .cal_st_o   (st_w)
  );

  rtd_delay_chain #(
    .DATA_W (DATA_W),
    .STAGES (STAGES),
    .TAP_W  (TAP_W)
  ) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .din_i  (din_i),
    .tap_i  (tap_w),
    .dout_o (dout_o)
  );

  assign tap_o    = tap_w;
  assign cal_st_o = st_w;

endmodule

// File: tb/rtd_autocal_pipe_tb.sv
module rtd_autocal_pipe_tb_top;

  localparam int DATA_W  = 16;
  localparam int STAGES  = 5;
  localparam int DELAY_W = 16;
  localparam int TAP_W   = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [DATA_W-1:0]  din = '0;
  logic [DATA_W-1:0]  dout;
  logic [DELAY_W-1:0] tgt_val = '0;
  logic               tgt_wr = 1'b0;
  logic [DELAY_W-1:0] meas_val = '0;
  logic               meas_vld = 1'b0;
  logic [TAP_W-1:0]   tap;
  logic [1:0]         cal_st;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit data_on = 1'b0;
  bit finished = 1'b0;

  // behavioural reference
  int m_tap = (STAGES + 1) / 2;
  int m_st  = 0;
  int m_tgt = 0;
  logic [DATA_W-1:0] hist [$];

  always #2.5 clk = ~clk;  // 200 MHz

  rtd_autocal_pipe #(
    .DATA_W (DATA_W), .STAGES (STAGES), .DELAY_W (DELAY_W), .TAP_W (TAP_W)
  ) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .din_i (din), .dout_o (dout),
    .tgt_val_i (tgt_val), .tgt_wr_i (tgt_wr),
    .meas_val_i (meas_val), .meas_vld_i (meas_vld),
    .tap_o (tap), .cal_st_o (cal_st)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) hist.push_front('0);
  end

  // model update on every rising edge (inputs stable since previous edge + 1)
  always @(posedge clk) begin
    cycles++;
    if (tgt_wr) begin
      m_tgt = int'(tgt_val);
      m_st  = 0;
    end else if (meas_vld) begin
      if (int'(meas_val) == m_tgt) m_st = 3;
      else if (int'(meas_val) > m_tgt) begin
        if (m_tap > 1) begin m_tap--; m_st = 0; end else m_st = 1;
      end else begin
        if (m_tap < STAGES) begin m_tap++; m_st = 0; end else m_st = 2;
      end
    end
    hist.push_front(din);
    if (hist.size() > 8) void'(hist.pop_back());
  end

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (!finished) begin
      check("R2 dout", int'(dout), int'(hist[m_tap-1]));
      check("R3 R4 R6 R7 R8 R9 tap", int'(tap), m_tap);
      check("R5 R6 R7 R8 status", int'(cal_st), m_st);
    end
  end

  // input data stream
  always @(posedge clk) begin
    #1;
    din = data_on ? DATA_W'($urandom) : '0;
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_target(int t);
    tgt_val = DELAY_W'(t); tgt_wr = 1'b1;
    step();
    tgt_wr = 1'b0;
  endtask

  task automatic measure(int m);
    meas_val = DELAY_W'(m); meas_vld = 1'b1;
    step();
    meas_vld = 1'b0;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    repeat (5) step();
    at_neg();
    check("R1 reset tap", int'(tap), 3);
    check("R1 reset status", int'(cal_st), 0);
    rst_n = 1'b1;
    repeat (6) step();
    at_neg();
    check("R1 tap after release", int'(tap), 3);
    data_on = 1'b1;
    repeat (10) step();

    wr_target(60); at_neg();
    check("R8 status after write", int'(cal_st), 0);
    check("R8 tap after write", int'(tap), 3);
    measure(61); at_neg();
    check("R3 tap down", int'(tap), 2);
    check("R3 status adjusting", int'(cal_st), 0);
    repeat (4) step();
    measure(60); at_neg();
    check("R5 locked", int'(cal_st), 3);
    check("R5 tap held", int'(tap), 2);

    for (int i = 0; i < 5; i++) begin
      meas_val = DELAY_W'(40 + 10 * i);
      step();
    end
    at_neg();
    check("R9 status held", int'(cal_st), 3);
    check("R9 tap held", int'(tap), 2);

    wr_target(62); at_neg();
    check("R8 status cleared", int'(cal_st), 0);
    check("R8 tap not moved", int'(tap), 2);
    for (int i = 0; i < 3; i++) begin
      measure(61);
      repeat (3) step();
    end
    at_neg();
    check("R4 tap up to ceiling", int'(tap), 5);
    measure(61); at_neg();
    check("R7 ceiling status", int'(cal_st), 2);
    check("R7 tap pinned", int'(tap), 5);

    // write and measurement in the same cycle: measurement dropped
    tgt_val = 50; tgt_wr = 1'b1; meas_val = 70; meas_vld = 1'b1;
    step();
    tgt_wr = 1'b0; meas_vld = 1'b0;
    at_neg();
    check("R8 same-cycle tap", int'(tap), 5);
    check("R8 same-cycle status", int'(cal_st), 0);

    for (int i = 0; i < 4; i++) begin
      measure(51);
      step();
    end
    at_neg();
    check("R3 tap down to floor", int'(tap), 1);
    measure(51); at_neg();
    check("R6 floor status", int'(cal_st), 1);
    check("R6 tap pinned", int'(tap), 1);
    measure(49); at_neg();
    check("R4 tap up from floor", int'(tap), 2);

    // random phase, reference model checks every cycle
    for (int i = 0; i < 600; i++) begin
      tgt_wr   = ($urandom_range(0, 15) == 0);
      tgt_val  = DELAY_W'($urandom_range(55, 65));
      meas_vld = ($urandom_range(0, 2) == 0);
      meas_val = DELAY_W'($urandom_range(55, 65));
      step();
    end
    tgt_wr = 1'b0; meas_vld = 1'b0;
    repeat (8) step();

    at_neg();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule